// File: doc/BRIEF.md
# Exception Acceptance and Return Controller

This block works beside a simple CPU core and decides, once per clock, whether a requested event is taken. The events are a synchronous exception, a nonmaskable interrupt, a user break and an ordinary interrupt. The decision depends on a single block bit in the current status word, which the core presents on `cur_sr`. When an event is taken, the block copies the current program counter and status word into shadow registers. It then issues a redirect to a handler address, which is a base input plus an offset chosen by the event class, together with a status load that sets the block bit.

With the block bit set, each event class behaves differently. An exception escalates into a manual-reset pulse and a redirect to the fixed reset address. An ordinary interrupt waits until the block bit clears. A nonmaskable interrupt either waits or is taken, depending on a software-set input. A user break is never escalated and is reported on its own strobe. A return strobe hands the shadow program counter and status back to the core.

All results are registered and appear one clock after the request is sampled. The core is expected to apply the status load before the block next samples `cur_sr`. While any redirect is being presented, the block takes no new request, so a request that is still asserted is never taken twice.

Top module: `exc_accept_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no requests, every output is 0, including `saved_pc` and `saved_sr`.
- R2: With status bit 28 clear, an exception request yields `redirect_valid` with `redirect_pc` = `vec_base` + 0x100.
- R3: With status bit 28 set, an exception request yields a one-cycle `mrst_pulse` together with `redirect_valid`, `redirect_pc` = 0xA0000000 and `sr_load_val` = 0x700000F0. The shadow registers are left unchanged.
- R4: With status bit 28 set, an ordinary interrupt is not taken. On the first sampled cycle with bit 28 clear, it is taken if still requested, and redirects to `vec_base` + 0x600.
- R5: A nonmaskable interrupt redirects to `vec_base` + 0x200. With status bit 28 set, it is taken only when `nmi_blk_take` is 1 and is otherwise held.
- R6: A user break is taken whatever the value of status bit 28 and never escalates. It is reported on `brk_valid` (never together with `redirect_valid`), with `redirect_pc` = `vec_base` + 0x300.
- R7: When an exception, nonmaskable interrupt, user break or ordinary interrupt is taken, `saved_pc` and `saved_sr` take `cur_pc` and `cur_sr`, and `sr_load_val` is `cur_sr` with bit 28 set.
- R8: At most one event is taken per cycle. The order is exception (escalated or not), then nonmaskable interrupt, then user break, then ordinary interrupt, then return. A return that coincides with a taken event is dropped.
- R9: A return strobe yields `redirect_valid` with `redirect_pc` = `saved_pc` and `sr_load_val` = `saved_sr`. The shadow registers are left unchanged.
- R10: In a cycle in which `redirect_valid` or `brk_valid` is high, every request, including the return strobe, is ignored.
- R11: The results of a request sampled at one rising edge appear right after that edge. `sr_load` is high in exactly the cycles in which `redirect_valid` or `brk_valid` is high. `redirect_pc` and `sr_load_val` hold their values between loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 1 | Synchronous exception request |
| nmi_req | input | 1 | Nonmaskable interrupt request |
| ubrk_req | input | 1 | User break request |
| irq_req | input | 1 | Ordinary interrupt request (level) |
| nmi_blk_take | input | 1 | Take a nonmaskable interrupt even while blocked |
| rte_strobe | input | 1 | Return-from-exception strobe |
| cur_pc | input | 32 | Current program counter |
| cur_sr | input | 32 | Current status word, block bit at 28 |
| vec_base | input | 32 | Handler base address |
| redirect_valid | output | 1 | Fetch redirect strobe |
| brk_valid | output | 1 | User break redirect strobe |
| redirect_pc | output | 32 | Redirect target address |
| sr_load | output | 1 | Status load strobe |
| sr_load_val | output | 32 | Status value to load |
| mrst_pulse | output | 1 | Manual-reset pulse |
| saved_pc | output | 32 | Shadow program counter |
| saved_sr | output | 32 | Shadow status word |

## Verification
A wrong arbitration decision appears at the ports on the very next cycle, as a wrong strobe, a wrong target address or a missing manual-reset pulse. A stale or corrupted shadow register stays hidden until the next return strobe, where it shows up as a wrong return address or status. For that reason the shadow outputs are also compared on every cycle. A broken in-flight guard shows up as a second redirect in the cycle directly after a taken level interrupt.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [2:0] {
    EV_NONE = 3'd0,
    EV_MRST = 3'd1,
    EV_EXC  = 3'd2,
    EV_NMI  = 3'd3,
    EV_UBRK = 3'd4,
    EV_IRQ  = 3'd5,
    EV_RTE  = 3'd6
  } ev_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic busy,
  input  logic blk,
  input  logic nmi_take,
  input  logic exc_req,
  input  logic nmi_req,
  input  logic ubrk_req,
  input  logic irq_req,
  input  logic rte_strobe,
  output ev_e  ev
);
  always_comb begin
    ev = EV_NONE;
    if (!busy) begin
      if (exc_req)                         ev = blk ? EV_MRST : EV_EXC;
      else if (nmi_req && (!blk || nmi_take)) ev = EV_NMI;
      else if (ubrk_req)                   ev = EV_UBRK;
      else if (irq_req && !blk)            ev = EV_IRQ;
      else if (rte_strobe)                 ev = EV_RTE;
    end
  end
endmodule

// File: rtl/exc_target.sv
module exc_target
  import exc_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              BL_POS   = 28,
  parameter logic [XLEN-1:0] RST_ADDR = 32'hA000_0000,
  parameter logic [XLEN-1:0] RST_SR   = 32'h7000_00F0,
  parameter logic [XLEN-1:0] OFF_EXC  = 32'h0000_0100,
  parameter logic [XLEN-1:0] OFF_NMI  = 32'h0000_0200,
  parameter logic [XLEN-1:0] OFF_UBRK = 32'h0000_0300,
  parameter logic [XLEN-1:0] OFF_IRQ  = 32'h0000_0600
) (
  input  ev_e             ev,
  input  logic [XLEN-1:0] base,
  input  logic [XLEN-1:0] cur_sr,
  input  logic [XLEN-1:0] shd_pc,
  input  logic [XLEN-1:0] shd_sr,
  output logic [XLEN-1:0] tgt_pc,
  output logic [XLEN-1:0] tgt_sr
);
  localparam logic [XLEN-1:0] BL_MASK = {{(XLEN-1){1'b0}}, 1'b1} << BL_POS;

  logic [XLEN-1:0] blocked_sr;
  assign blocked_sr = cur_sr | BL_MASK;

  always_comb begin
    tgt_pc = '0;
    tgt_sr = '0;
    unique case (ev)
      EV_MRST: begin tgt_pc = RST_ADDR;         tgt_sr = RST_SR;     end
      EV_EXC:  begin tgt_pc = base + OFF_EXC;   tgt_sr = blocked_sr; end
      EV_NMI:  begin tgt_pc = base + OFF_NMI;   tgt_sr = blocked_sr; end
      EV_UBRK: begin tgt_pc = base + OFF_UBRK;  tgt_sr = blocked_sr; end
      EV_IRQ:  begin tgt_pc = base + OFF_IRQ;   tgt_sr = blocked_sr; end
      EV_RTE:  begin tgt_pc = shd_pc;           tgt_sr = shd_sr;     end
      default: begin tgt_pc = '0;               tgt_sr = '0;         end
    endcase
  end
endmodule

// File: rtl/exc_shadow.sv
module exc_shadow #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            save_en,
  input  logic [XLEN-1:0] pc_in,
  input  logic [XLEN-1:0] sr_in,
  output logic [XLEN-1:0] shd_pc,
  output logic [XLEN-1:0] shd_sr
);
  logic [XLEN-1:0] pc_d, sr_d;

  always_comb begin
    pc_d = shd_pc;
    sr_d = shd_sr;
    if (save_en) begin
      pc_d = pc_in;
      sr_d = sr_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_pc <= '0;
      shd_sr <= '0;
    end else begin
      shd_pc <= pc_d;
      shd_sr <= sr_d;
    end
  end

  // R7: a save captures the presented PC and status
  p_save_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    save_en |=> (shd_pc == $past(pc_in)) && (shd_sr == $past(sr_in)));

  // R9, R3: without a save the shadow contents stay put
  p_shadow_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !save_en |=> $stable(shd_pc) && $stable(shd_sr));
endmodule

// File: rtl/exc_accept_ctrl.sv
module exc_accept_ctrl
  import exc_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              BL_POS   = 28,
  parameter logic [XLEN-1:0] RST_ADDR = 32'hA000_0000,
  parameter logic [XLEN-1:0] RST_SR   = 32'h7000_00F0,
  parameter logic [XLEN-1:0] OFF_EXC  = 32'h0000_0100,
  parameter logic [XLEN-1:0] OFF_NMI  = 32'h0000_0200,
  parameter logic [XLEN-1:0] OFF_UBRK = 32'h0000_0300,
  parameter logic [XLEN-1:0] OFF_IRQ  = 32'h0000_0600
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exc_req,
  input  logic            nmi_req,
  input  logic            ubrk_req,
  input  logic            irq_req,
  input  logic            nmi_blk_take,
  input  logic            rte_strobe,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] cur_sr,
  input  logic [XLEN-1:0] vec_base,
  output logic            redirect_valid,
  output logic            brk_valid,
  output logic [XLEN-1:0] redirect_pc,
  output logic            sr_load,
  output logic [XLEN-1:0] sr_load_val,
  output logic            mrst_pulse,
  output logic [XLEN-1:0] saved_pc,
  output logic [XLEN-1:0] saved_sr
);
  ev_e             ev;
  logic            busy, blk, save_en;
  logic [XLEN-1:0] tgt_pc, tgt_sr;
  logic            rv_d, bv_d, mr_d, ld_d;

  assign busy = redirect_valid | brk_valid;
  assign blk  = cur_sr[BL_POS];

  exc_arbiter u_arb (
    .busy       (busy),
    .blk        (blk),
    .nmi_take   (nmi_blk_take),
    .exc_req    (exc_req),
    .nmi_req    (nmi_req),
    .ubrk_req   (ubrk_req),
    .irq_req    (irq_req),
    .rte_strobe (rte_strobe),
    .ev         (ev)
  );

  exc_target #(
    .XLEN(XLEN), .BL_POS(BL_POS), .RST_ADDR(RST_ADDR), .RST_SR(RST_SR),
    .OFF_EXC(OFF_EXC), .OFF_NMI(OFF_NMI), .OFF_UBRK(OFF_UBRK), .OFF_IRQ(OFF_IRQ)
  ) u_tgt (
    .ev     (ev),
    .base   (vec_base),
    .cur_sr (cur_sr),
    .shd_pc (saved_pc),
    .shd_sr (saved_sr),
    .tgt_pc (tgt_pc),
    .tgt_sr (tgt_sr)
  );

  assign save_en = (ev == EV_EXC) || (ev == EV_NMI) ||
                   (ev == EV_UBRK) || (ev == EV_IRQ);

  exc_shadow #(.XLEN(XLEN)) u_shd (
    .clk     (clk),
    .rst_n   (rst_n),
    .save_en (save_en),
    .pc_in   (cur_pc),
    .sr_in   (cur_sr),
    .shd_pc  (saved_pc),
    .shd_sr  (saved_sr)
  );

  // next-state decode
  always_comb begin
    rv_d = (ev == EV_MRST) || (ev == EV_EXC) || (ev == EV_NMI) ||
           (ev == EV_IRQ)  || (ev == EV_RTE);
    bv_d = (ev == EV_UBRK);
    mr_d = (ev == EV_MRST);
    ld_d = (ev != EV_NONE);
  end

  // output registers; target and status held unless loaded
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect_valid <= 1'b0;
      brk_valid      <= 1'b0;
      mrst_pulse     <= 1'b0;
      sr_load        <= 1'b0;
      redirect_pc    <= '0;
      sr_load_val    <= '0;
    end else begin
      redirect_valid <= rv_d;
      brk_valid      <= bv_d;
      mrst_pulse     <= mr_d;
      sr_load        <= ld_d;
      if (ld_d) begin
        redirect_pc <= tgt_pc;
        sr_load_val <= tgt_sr;
      end
    end
  end

  // R3: blocked exception escalates to the reset target
  p_escalate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && exc_req && blk) |=> mrst_pulse && redirect_valid &&
                                  (redirect_pc == RST_ADDR));

  // R4: a lone blocked ordinary interrupt produces no redirect
  p_irq_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (blk && irq_req && !exc_req && !nmi_req && !ubrk_req && !rte_strobe)
      |=> !redirect_valid && !brk_valid);

  // R5: a lone blocked NMI waits unless software allows it
  p_nmi_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (blk && !nmi_blk_take && nmi_req && !exc_req && !ubrk_req &&
     !irq_req && !rte_strobe) |=> !redirect_valid && !brk_valid);

  // R6: the two redirect strobes never coincide
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({redirect_valid, brk_valid}));

  // R9: a lone return hands back the shadow contents
  p_return_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && rte_strobe && !exc_req && !nmi_req && !ubrk_req && !irq_req)
      |=> redirect_valid && (redirect_pc == $past(saved_pc)) &&
          (sr_load_val == $past(saved_sr)));

  // R10: no back-to-back redirects
  p_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid || brk_valid) |=> !redirect_valid && !brk_valid && !mrst_pulse);

  // R11: a status load goes with exactly one redirect strobe
  p_load_pair_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sr_load == (redirect_valid || brk_valid));
endmodule

// File: tb/exc_accept_ctrl_bench.sv
module exc_accept_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        exc_req, nmi_req, ubrk_req, irq_req, nmi_blk_take, rte_strobe;
  logic [31:0] cur_pc, cur_sr, vec_base;
  logic        redirect_valid, brk_valid, sr_load, mrst_pulse;
  logic [31:0] redirect_pc, sr_load_val, saved_pc, saved_sr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference model state
  logic [31:0] m_spc = '0, m_ssr = '0, m_pc = '0, m_slv = '0;
  logic        m_rv = 0, m_bv = 0, m_mr = 0, m_ld = 0;

  always #10 clk = ~clk;

  exc_accept_ctrl u_exc_accept_ctrl (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .nmi_req(nmi_req),
    .ubrk_req(ubrk_req), .irq_req(irq_req), .nmi_blk_take(nmi_blk_take),
    .rte_strobe(rte_strobe), .cur_pc(cur_pc), .cur_sr(cur_sr),
    .vec_base(vec_base), .redirect_valid(redirect_valid), .brk_valid(brk_valid),
    .redirect_pc(redirect_pc), .sr_load(sr_load), .sr_load_val(sr_load_val),
    .mrst_pulse(mrst_pulse), .saved_pc(saved_pc), .saved_sr(saved_sr)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag, input string stag);
    chk(tag,  "flags{rv,bv,mr,ld}", {28'd0, redirect_valid, brk_valid, mrst_pulse, sr_load},
                                    {28'd0, m_rv, m_bv, m_mr, m_ld});
    chk(tag,  "redirect_pc", redirect_pc, m_pc);
    chk(tag,  "sr_load_val", sr_load_val, m_slv);
    chk(stag, "saved_pc", saved_pc, m_spc);
    chk(stag, "saved_sr", saved_sr, m_ssr);
  endtask

  // one cycle: apply inputs, predict, clock, compare
  task automatic step(input logic e, input logic n, input logic u, input logic i,
                      input logic r, input logic cfg,
                      input logic [31:0] pc, input logic [31:0] sr);
    logic  blk, busy, saving;
    int    kind;
    string tag, stag;
    exc_req = e; nmi_req = n; ubrk_req = u; irq_req = i; rte_strobe = r;
    nmi_blk_take = cfg; cur_pc = pc; cur_sr = sr;
    blk  = sr[28];
    busy = m_rv | m_bv;
    kind = 0;
    if (!busy) begin
      if (e)                      kind = blk ? 1 : 2;
      else if (n && (!blk || cfg)) kind = 3;
      else if (u)                 kind = 4;
      else if (i && !blk)         kind = 5;
      else if (r)                 kind = 6;
    end
    case (kind)
      1: tag = "R3"; 2: tag = "R2"; 3: tag = "R5";
      4: tag = "R6"; 5: tag = "R4"; 6: tag = "R9";
      default: begin
        if (busy)                   tag = "R10";
        else if (i && blk)          tag = "R4";
        else if (n && blk && !cfg)  tag = "R5";
        else                        tag = "R11";
      end
    endcase
    if ((e + n + u + i + r) > 1 && !busy) tag = "R8";
    saving = (kind >= 2 && kind <= 5);
    stag = saving ? "R7" : tag;
    m_rv = (kind == 1) || (kind == 2) || (kind == 3) || (kind == 5) || (kind == 6);
    m_bv = (kind == 4);
    m_mr = (kind == 1);
    m_ld = (kind != 0);
    case (kind)
      1: begin m_pc = 32'hA000_0000;       m_slv = 32'h7000_00F0; end
      2: begin m_pc = vec_base + 32'h100;  m_slv = sr | 32'h1000_0000; end
      3: begin m_pc = vec_base + 32'h200;  m_slv = sr | 32'h1000_0000; end
      4: begin m_pc = vec_base + 32'h300;  m_slv = sr | 32'h1000_0000; end
      5: begin m_pc = vec_base + 32'h600;  m_slv = sr | 32'h1000_0000; end
      6: begin m_pc = m_spc;               m_slv = m_ssr; end
      default: ;
    endcase
    if (saving) begin
      m_spc = pc;
      m_ssr = sr;
    end
    @(posedge clk);
    @(negedge clk);
    compare_all(tag, stag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    exc_req = 0; nmi_req = 0; ubrk_req = 0; irq_req = 0;
    nmi_blk_take = 0; rte_strobe = 0;
    cur_pc = '0; cur_sr = '0; vec_base = 32'h8000_0000;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    compare_all("R1", "R1");
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0, 32'h0, 32'h0);

    // exhaustive block-bit / config / request combinations
    for (int bl = 0; bl < 2; bl++) begin
      for (int cfg = 0; cfg < 2; cfg++) begin
        for (int c = 0; c < 32; c++) begin
          logic [31:0] pc, sr;
          pc = 32'h1000_0000 + (c << 4) + (cfg << 12) + (bl << 13);
          sr = 32'h4000_00F0 | (bl << 28) | c;
          step(c[4], c[3], c[2], c[1], c[0], 1'(cfg), pc, sr);
          step(0, 0, 0, 0, 0, 1'(cfg), pc + 2, sr);
        end
      end
    end

    // R4: interrupt held while blocked, taken on first unblocked cycle
    vec_base = 32'h0C00_0000;
    step(0, 0, 0, 1, 0, 0, 32'h2000_0000, 32'h5000_0001);
    step(0, 0, 0, 1, 0, 0, 32'h2000_0002, 32'h5000_0001);
    step(0, 0, 0, 1, 0, 0, 32'h2000_0004, 32'h5000_0001);
    step(0, 0, 0, 1, 0, 0, 32'h2000_0006, 32'h4000_0001);
    step(0, 0, 0, 0, 0, 0, 32'h2000_0008, 32'h5000_0001);
    // R5: held NMI, then unblocked
    step(0, 1, 0, 0, 0, 0, 32'h2100_0000, 32'h1000_0002);
    step(0, 1, 0, 0, 0, 0, 32'h2100_0002, 32'h1000_0002);
    step(0, 1, 0, 0, 0, 0, 32'h2100_0004, 32'h0000_0002);
    step(0, 0, 0, 0, 0, 0, 32'h2100_0006, 32'h1000_0002);
    // R10: level interrupt kept high back to back
    step(0, 0, 0, 1, 0, 0, 32'h2200_0000, 32'h0000_0003);
    step(0, 0, 0, 1, 0, 0, 32'h2200_0002, 32'h0000_0003);
    step(0, 0, 0, 1, 0, 0, 32'h2200_0004, 32'h0000_0004);
    step(0, 0, 0, 0, 0, 0, 32'h2200_0006, 32'h1000_0004);
    // R9: return after a taken exception
    step(1, 0, 0, 0, 0, 0, 32'h2300_0000, 32'h0000_0055);
    step(0, 0, 0, 0, 0, 0, 32'h0C00_0100, 32'h1000_0055);
    step(0, 0, 0, 0, 1, 0, 32'h0C00_0102, 32'h1000_0055);
    step(0, 0, 0, 0, 0, 0, 32'h2300_0000, 32'h0000_0055);
    // R3: escalation leaves shadow untouched
    step(1, 0, 0, 0, 0, 1, 32'h2400_0000, 32'h1000_0066);
    step(0, 0, 0, 0, 0, 0, 32'hA000_0000, 32'h7000_00F0);
    // R6: user break while blocked
    step(0, 0, 1, 0, 0, 0, 32'h2500_0000, 32'h1000_0077);
    step(0, 0, 0, 0, 0, 0, 32'h0C00_0300, 32'h1000_0077);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule